// File: doc/BRIEF.md
# Commit-Stage Squash Arbiter

This block decides, for each hardware thread of a multithreaded out-of-order core, which squash request the retirement stage acts on in a given cycle and what it tells the earlier pipeline stages afterwards. Each thread can receive three kinds of request. A delayed trap squash is armed when retirement raises a trap and fires a fixed number of cycles later. A thread-context squash arrives from outside. An execute-stage squash carries a sequence number, an include-self flag, a mispredict flag and a redirect PC.

The requests are ranked by origin. A trap squash wins over a thread-context squash, which wins over an execute-stage squash. An execute-stage squash that is younger than the thread's youngest valid instruction is dropped, and so is one that arrives while a trap is pending. Each accepted squash moves the thread into a reorder-buffer squashing state. For one cycle the block broadcasts squash, rob-squashing, the boundary sequence number and the redirect PC. It then holds rob-squashing until the reorder buffer reports that it has finished. When every thread is squashing, the block raises a retirement block, and instruction insertion is ignored while that block is raised.

Top module: `commit_squash_arbiter`

## Requirements
- R1: After reset every thread state is Idle (code 0), all broadcast outputs, trap-in-flight flags, conflict flags and mispredict counters are zero, and retire_block is low.
- R2: Thread state encodings are Idle=0, Running=1, RobSquashing=2, TrapPending=3, FetchTrapPending=4. An accepted insertion moves an Idle thread to Running. RobSquashing returns to Running in the cycle after rob_done is sampled high, unless a new squash is accepted in that cycle.
- R3: An execute-stage squash is accepted only when the thread is not TrapPending and its sequence number is less than or equal to the thread's youngest valid sequence number. A rejected squash produces no broadcast.
- R4: For an accepted execute-stage squash, the boundary is the given sequence number minus one (modulo 2^SEQ_W) when include-self is set, and the number unchanged otherwise. On the next clock the block drives bc_sq=1, bc_robsq=1, bc_done_seq=boundary, bc_pc=the supplied redirect PC and bc_mis=the mispredict flag. The boundary also becomes the thread's youngest valid sequence number.
- R5: bc_sq is high for exactly one cycle per accepted squash, and the done-sequence and PC fields are zero in cycles without one. bc_robsq stays high in every cycle the thread is in RobSquashing.
- R6: When a trap is raised with none in flight and no squash is accepted in that cycle, trap_inflight rises and the state becomes TrapPending. Exactly TRAP_LAT clocks later a full-thread squash fires and trap_inflight clears. A trap raised while one is already in flight is ignored.
- R7: A full-thread squash (trap or thread-context) uses last_cmt_seq as the boundary when rob_empty is high, and the head sequence number minus one otherwise. The redirect PC is resume_pc.
- R8: In one thread and one cycle, a firing trap squash takes priority over a thread-context squash, which takes priority over an execute-stage squash. A trap firing in the same cycle as a thread-context request sets sq_conflict for one cycle.
- R9: retire_block is high exactly when every thread is in RobSquashing. While it is high, insertions are ignored and leave the youngest valid sequence number unchanged.
- R10: Each accepted execute-stage squash with the mispredict flag set increments that thread's mispredict counter, which wraps at 2^CNT_W.
- R11: A thread-context squash that arrives while a trap is in flight, other than in the cycle the trap fires, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_raise | input | NT | Trap raised at retirement, per thread |
| ctx_sq | input | NT | Thread-context squash request |
| ex_vld | input | NT | Execute-stage squash request |
| ex_seq | input | NT*SEQ_W | Execute-stage squash sequence number |
| ex_incl | input | NT | Include the squashing instruction itself |
| ex_mis | input | NT | Squash caused by a branch mispredict |
| ex_pc | input | NT*PC_W | Execute-stage redirect PC |
| rob_done | input | NT | Reorder buffer finished squashing |
| rob_empty | input | NT | Reorder buffer holds no entry for the thread |
| rob_head_seq | input | NT*SEQ_W | Sequence number of the head entry |
| last_cmt_seq | input | NT*SEQ_W | Last committed sequence number |
| resume_pc | input | NT*PC_W | Restart PC for full-thread squashes |
| ins_vld | input | NT | New instruction inserted |
| ins_seq | input | NT*SEQ_W | Sequence number of the inserted instruction |
| bc_sq | output | NT | Squash broadcast |
| bc_robsq | output | NT | Reorder-buffer-squashing broadcast |
| bc_mis | output | NT | Broadcast squash was a mispredict |
| bc_done_seq | output | NT*SEQ_W | Broadcast boundary sequence number |
| bc_pc | output | NT*PC_W | Broadcast redirect PC |
| thr_state | output | NT*3 | Per-thread state code |
| trap_inflight | output | NT | Trap armed and waiting to fire |
| sq_conflict | output | NT | Trap fire and context squash met |
| mis_cnt | output | NT*CNT_W | Per-thread mispredict counter |
| retire_block | output | 1 | All threads squashing |

## Verification
The bench builds the block with two threads, an 8-bit sequence number, a 16-bit PC, a trap latency of 3 and a 4-bit mispredict counter. With only two threads, random traffic often puts both threads into RobSquashing in the same cycle, which exercises the retirement block. The 8-bit sequence numbers let the head-minus-one and include-self boundaries wrap, the short trap latency lets many traps fire and meet context requests, and the narrow counter wraps within the run.

// File: rtl/sqa_pkg.sv
package sqa_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RUN      = 3'd1,
        ST_ROBSQ    = 3'd2,
        ST_TRAPP    = 3'd3,
        ST_FTRAPP   = 3'd4
    } sq_state_e;

    localparam int ST_W = 3;

    // Per-thread, per-cycle squash selection
    typedef struct packed {
        logic full;      // trap or context squash chosen
        logic ex_ok;     // execute-stage squash accepted
        logic any;       // some squash accepted
        logic conflict;  // trap fire met a context request
    } sq_pick_t;

    function automatic logic older_or_same(input logic [63:0] a, input logic [63:0] b);
        return a <= b;
    endfunction

endpackage

// File: rtl/sqa_trap_timer.sv
module sqa_trap_timer #(
    parameter int LAT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic raise,
    input  logic block,
    output logic inflight,
    output logic fire,
    output logic arm
);
    localparam int CW = $clog2(LAT + 1);

    logic [CW-1:0] cnt_q;
    logic          infl_q;

    assign fire     = infl_q && (cnt_q == CW'(1));
    assign arm      = raise && !infl_q && !block;
    assign inflight = infl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            infl_q <= 1'b0;
            cnt_q  <= '0;
        end else if (fire) begin
            infl_q <= 1'b0;
            cnt_q  <= '0;
        end else if (arm) begin
            infl_q <= 1'b1;
            cnt_q  <= CW'(LAT);
        end else if (infl_q) begin
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    // R6: firing clears the in-flight flag
    p_fire_clears_r6: assert property (@(posedge clk) disable iff (rst)
        fire |=> !inflight);
    // R6: arming loads the full latency
    p_arm_loads_r6: assert property (@(posedge clk) disable iff (rst)
        arm |=> (inflight && cnt_q == CW'(LAT)));
    // R6: an armed timer never sits at zero
    p_cnt_live_r6: assert property (@(posedge clk) disable iff (rst)
        inflight |-> (cnt_q != '0));

endmodule

// File: rtl/sqa_thread_ctl.sv
module sqa_thread_ctl
    import sqa_pkg::*;
#(
    parameter int SEQ_W = 16,
    parameter int PC_W  = 32,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             all_sq,
    input  logic             fire,
    input  logic             inflight,
    input  logic             arm,
    input  logic             ctx_sq,
    input  logic             ex_vld,
    input  logic [SEQ_W-1:0] ex_seq,
    input  logic             ex_incl,
    input  logic             ex_mis,
    input  logic [PC_W-1:0]  ex_pc,
    input  logic             rob_done,
    input  logic             rob_empty,
    input  logic [SEQ_W-1:0] rob_head_seq,
    input  logic [SEQ_W-1:0] last_cmt_seq,
    input  logic [PC_W-1:0]  resume_pc,
    input  logic             ins_vld,
    input  logic [SEQ_W-1:0] ins_seq,
    output logic             sq_any,
    output logic             bc_sq,
    output logic             bc_robsq,
    output logic             bc_mis,
    output logic [SEQ_W-1:0] bc_done_seq,
    output logic [PC_W-1:0]  bc_pc,
    output logic             sq_conflict,
    output logic [CNT_W-1:0] mis_cnt,
    output sq_state_e        state
);
    sq_state_e        st_q;
    logic [SEQ_W-1:0] young_q;
    logic [CNT_W-1:0] cnt_q;
    sq_pick_t         pick;
    logic [SEQ_W-1:0] full_bnd;
    logic [SEQ_W-1:0] ex_bnd;
    logic [SEQ_W-1:0] bnd;
    logic             ctx_ok;
    logic             ins_ok;

    always_comb begin
        ctx_ok        = ctx_sq && !inflight;
        pick.full     = fire || ctx_ok;
        pick.ex_ok    = !pick.full && ex_vld && (st_q != ST_TRAPP) &&
                        older_or_same(64'(ex_seq), 64'(young_q));
        pick.any      = pick.full || pick.ex_ok;
        pick.conflict = fire && ctx_sq;
        full_bnd      = rob_empty ? last_cmt_seq : (rob_head_seq - 1'b1);
        ex_bnd        = ex_incl ? (ex_seq - 1'b1) : ex_seq;
        bnd           = pick.full ? full_bnd : ex_bnd;
        ins_ok        = ins_vld && !all_sq;
    end

    assign sq_any = pick.any;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            young_q     <= '0;
            cnt_q       <= '0;
            bc_sq       <= 1'b0;
            bc_robsq    <= 1'b0;
            bc_mis      <= 1'b0;
            bc_done_seq <= '0;
            bc_pc       <= '0;
            sq_conflict <= 1'b0;
        end else begin
            bc_sq       <= pick.any;
            bc_robsq    <= pick.any || ((st_q == ST_ROBSQ) && !rob_done);
            bc_mis      <= pick.ex_ok && ex_mis;
            bc_done_seq <= pick.any ? bnd : '0;
            bc_pc       <= pick.full ? resume_pc : (pick.ex_ok ? ex_pc : '0);
            sq_conflict <= pick.conflict;

            if (pick.any)
                st_q <= ST_ROBSQ;
            else if (arm)
                st_q <= ST_TRAPP;
            else if ((st_q == ST_ROBSQ) && rob_done)
                st_q <= ST_RUN;
            else if ((st_q == ST_IDLE) && ins_ok)
                st_q <= ST_RUN;

            if (pick.any)
                young_q <= bnd;
            else if (ins_ok)
                young_q <= ins_seq;

            if (pick.ex_ok && ex_mis)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign mis_cnt = cnt_q;
    assign state   = st_q;

    // R4: a squash broadcast always carries rob-squashing and leaves the thread squashing
    p_sq_pair_r4: assert property (@(posedge clk) disable iff (rst)
        bc_sq |-> (bc_robsq && st_q == ST_ROBSQ));
    // R5: rob-squashing is driven in every squashing cycle
    p_robsq_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ROBSQ) |-> bc_robsq);
    // R3: nothing from execute while a trap waits and no full squash is chosen
    p_trap_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (ex_vld && st_q == ST_TRAPP && !fire && !ctx_ok) |=> !bc_sq);
    // R8: a conflict comes with the trap squash broadcast
    p_conflict_r8: assert property (@(posedge clk) disable iff (rst)
        sq_conflict |-> bc_sq);
    // R10: the counter moves only with a mispredict broadcast
    p_cnt_step_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(cnt_q) |-> bc_mis);

endmodule

// File: rtl/commit_squash_arbiter.sv
module commit_squash_arbiter
    import sqa_pkg::*;
#(
    parameter int NT       = 2,
    parameter int SEQ_W    = 16,
    parameter int PC_W     = 32,
    parameter int TRAP_LAT = 4,
    parameter int CNT_W    = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NT-1:0]         trap_raise,
    input  logic [NT-1:0]         ctx_sq,
    input  logic [NT-1:0]         ex_vld,
    input  logic [NT*SEQ_W-1:0]   ex_seq,
    input  logic [NT-1:0]         ex_incl,
    input  logic [NT-1:0]         ex_mis,
    input  logic [NT*PC_W-1:0]    ex_pc,
    input  logic [NT-1:0]         rob_done,
    input  logic [NT-1:0]         rob_empty,
    input  logic [NT*SEQ_W-1:0]   rob_head_seq,
    input  logic [NT*SEQ_W-1:0]   last_cmt_seq,
    input  logic [NT*PC_W-1:0]    resume_pc,
    input  logic [NT-1:0]         ins_vld,
    input  logic [NT*SEQ_W-1:0]   ins_seq,
    output logic [NT-1:0]         bc_sq,
    output logic [NT-1:0]         bc_robsq,
    output logic [NT-1:0]         bc_mis,
    output logic [NT*SEQ_W-1:0]   bc_done_seq,
    output logic [NT*PC_W-1:0]    bc_pc,
    output logic [NT*ST_W-1:0]    thr_state,
    output logic [NT-1:0]         trap_inflight,
    output logic [NT-1:0]         sq_conflict,
    output logic [NT*CNT_W-1:0]   mis_cnt,
    output logic                  retire_block
);
    logic [NT-1:0] squashing;
    logic [NT-1:0] fire;
    logic [NT-1:0] arm;
    logic [NT-1:0] sq_any;
    logic          all_sq;

    assign all_sq       = &squashing;
    assign retire_block = all_sq;

    for (genvar t = 0; t < NT; t++) begin : g_thr
        sq_state_e st;

        sqa_trap_timer #(.LAT(TRAP_LAT)) i_timer (
            .clk      (clk),
            .rst      (rst),
            .raise    (trap_raise[t]),
            .block    (sq_any[t]),
            .inflight (trap_inflight[t]),
            .fire     (fire[t]),
            .arm      (arm[t])
        );

        sqa_thread_ctl #(.SEQ_W(SEQ_W), .PC_W(PC_W), .CNT_W(CNT_W)) i_ctl (
            .clk          (clk),
            .rst          (rst),
            .all_sq       (all_sq),
            .fire         (fire[t]),
            .inflight     (trap_inflight[t]),
            .arm          (arm[t]),
            .ctx_sq       (ctx_sq[t]),
            .ex_vld       (ex_vld[t]),
            .ex_seq       (ex_seq[t*SEQ_W +: SEQ_W]),
            .ex_incl      (ex_incl[t]),
            .ex_mis       (ex_mis[t]),
            .ex_pc        (ex_pc[t*PC_W +: PC_W]),
            .rob_done     (rob_done[t]),
            .rob_empty    (rob_empty[t]),
            .rob_head_seq (rob_head_seq[t*SEQ_W +: SEQ_W]),
            .last_cmt_seq (last_cmt_seq[t*SEQ_W +: SEQ_W]),
            .resume_pc    (resume_pc[t*PC_W +: PC_W]),
            .ins_vld      (ins_vld[t]),
            .ins_seq      (ins_seq[t*SEQ_W +: SEQ_W]),
            .sq_any       (sq_any[t]),
            .bc_sq        (bc_sq[t]),
            .bc_robsq     (bc_robsq[t]),
            .bc_mis       (bc_mis[t]),
            .bc_done_seq  (bc_done_seq[t*SEQ_W +: SEQ_W]),
            .bc_pc        (bc_pc[t*PC_W +: PC_W]),
            .sq_conflict  (sq_conflict[t]),
            .mis_cnt      (mis_cnt[t*CNT_W +: CNT_W]),
            .state        (st)
        );

        assign squashing[t]                 = (st == ST_ROBSQ);
        assign thr_state[t*ST_W +: ST_W]    = st;
    end

    // R9: a raised block means every thread drives rob-squashing
    p_block_robsq_r9: assert property (@(posedge clk) disable iff (rst)
        retire_block |-> (&bc_robsq));
    // R6: a trap waiting in flight never coexists with an Idle state
    p_trap_state_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(trap_inflight[0]) |-> (thr_state[ST_W-1:0] == 3'(ST_TRAPP)));

endmodule

// File: tb/test_commit_squash_arbiter.sv
module test_commit_squash_arbiter;
    localparam int NT  = 2;
    localparam int SW  = 8;
    localparam int PW  = 16;
    localparam int LAT = 3;
    localparam int CW  = 4;
    localparam int SM  = (1 << SW) - 1;
    localparam int CM  = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NT-1:0]    trap_raise, ctx_sq, ex_vld, ex_incl, ex_mis, rob_done, rob_empty, ins_vld;
    logic [NT*SW-1:0] ex_seq, rob_head_seq, last_cmt_seq, ins_seq;
    logic [NT*PW-1:0] ex_pc, resume_pc;
    logic [NT-1:0]    bc_sq, bc_robsq, bc_mis, trap_inflight, sq_conflict;
    logic [NT*SW-1:0] bc_done_seq;
    logic [NT*PW-1:0] bc_pc;
    logic [NT*3-1:0]  thr_state;
    logic [NT*CW-1:0] mis_cnt;
    logic             retire_block;

    int errors = 0;
    int checks = 0;

    // reference model state
    int m_st[NT], m_young[NT], m_cnt[NT], m_infl[NT], m_tc[NT];
    int m_sq[NT], m_rsq[NT], m_mis[NT], m_done[NT], m_pc[NT], m_conf[NT];

    always #5 clk = ~clk;

    commit_squash_arbiter #(.NT(NT), .SEQ_W(SW), .PC_W(PW), .TRAP_LAT(LAT), .CNT_W(CW))
        i_commit_squash_arbiter (
        .clk(clk), .rst(rst), .trap_raise(trap_raise), .ctx_sq(ctx_sq),
        .ex_vld(ex_vld), .ex_seq(ex_seq), .ex_incl(ex_incl), .ex_mis(ex_mis),
        .ex_pc(ex_pc), .rob_done(rob_done), .rob_empty(rob_empty),
        .rob_head_seq(rob_head_seq), .last_cmt_seq(last_cmt_seq),
        .resume_pc(resume_pc), .ins_vld(ins_vld), .ins_seq(ins_seq),
        .bc_sq(bc_sq), .bc_robsq(bc_robsq), .bc_mis(bc_mis),
        .bc_done_seq(bc_done_seq), .bc_pc(bc_pc), .thr_state(thr_state),
        .trap_inflight(trap_inflight), .sq_conflict(sq_conflict),
        .mis_cnt(mis_cnt), .retire_block(retire_block));

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model_update();
        bit allsq;
        if (rst) begin
            for (int t = 0; t < NT; t++) begin
                m_st[t] = 0; m_young[t] = 0; m_cnt[t] = 0; m_infl[t] = 0; m_tc[t] = 0;
                m_sq[t] = 0; m_rsq[t] = 0; m_mis[t] = 0; m_done[t] = 0; m_pc[t] = 0; m_conf[t] = 0;
            end
            return;
        end
        allsq = 1'b1;
        for (int t = 0; t < NT; t++) if (m_st[t] != 2) allsq = 1'b0;
        for (int t = 0; t < NT; t++) begin
            int eseq, bnd;
            bit fire, ctxok, full, exok, any, armed, insok;
            eseq  = int'(ex_seq[t*SW +: SW]);
            fire  = (m_infl[t] != 0) && (m_tc[t] == 1);
            ctxok = ctx_sq[t] && (m_infl[t] == 0);
            full  = fire || ctxok;
            exok  = !full && ex_vld[t] && (m_st[t] != 3) && (eseq <= m_young[t]);
            any   = full || exok;
            if (full)
                bnd = rob_empty[t] ? int'(last_cmt_seq[t*SW +: SW])
                                   : ((int'(rob_head_seq[t*SW +: SW]) - 1) & SM);
            else
                bnd = ex_incl[t] ? ((eseq - 1) & SM) : eseq;
            armed = trap_raise[t] && (m_infl[t] == 0) && !any;
            insok = ins_vld[t] && !allsq;

            m_rsq[t]  = (any || (m_st[t] == 2 && !rob_done[t])) ? 1 : 0;
            m_sq[t]   = any ? 1 : 0;
            m_mis[t]  = (exok && ex_mis[t]) ? 1 : 0;
            m_done[t] = any ? bnd : 0;
            m_pc[t]   = full ? int'(resume_pc[t*PW +: PW]) : (exok ? int'(ex_pc[t*PW +: PW]) : 0);
            m_conf[t] = (fire && ctx_sq[t]) ? 1 : 0;

            if (any) m_st[t] = 2;
            else if (armed) m_st[t] = 3;
            else if (m_st[t] == 2 && rob_done[t]) m_st[t] = 1;
            else if (m_st[t] == 0 && insok) m_st[t] = 1;

            if (any) m_young[t] = bnd;
            else if (insok) m_young[t] = int'(ins_seq[t*SW +: SW]);

            if (exok && ex_mis[t]) m_cnt[t] = (m_cnt[t] + 1) & CM;

            if (fire) begin m_infl[t] = 0; m_tc[t] = 0; end
            else if (armed) begin m_infl[t] = 1; m_tc[t] = LAT; end
            else if (m_infl[t] != 0) m_tc[t] = m_tc[t] - 1;
        end
    endtask

    task automatic compare_all();
        bit allsq;
        allsq = 1'b1;
        for (int t = 0; t < NT; t++) begin
            if (m_st[t] != 2) allsq = 1'b0;
            chk($sformatf("R2 state t%0d", t), 64'(thr_state[t*3 +: 3]), 64'(m_st[t]));
            chk($sformatf("R5 bc_sq t%0d", t), 64'(bc_sq[t]), 64'(m_sq[t]));
            chk($sformatf("R5 bc_robsq t%0d", t), 64'(bc_robsq[t]), 64'(m_rsq[t]));
            chk($sformatf("R4 done_seq t%0d", t), 64'(bc_done_seq[t*SW +: SW]), 64'(m_done[t]));
            chk($sformatf("R4 pc t%0d", t), 64'(bc_pc[t*PW +: PW]), 64'(m_pc[t]));
            chk($sformatf("R4 bc_mis t%0d", t), 64'(bc_mis[t]), 64'(m_mis[t]));
            chk($sformatf("R6 inflight t%0d", t), 64'(trap_inflight[t]), 64'(m_infl[t]));
            chk($sformatf("R8 conflict t%0d", t), 64'(sq_conflict[t]), 64'(m_conf[t]));
            chk($sformatf("R10 mis_cnt t%0d", t), 64'(mis_cnt[t*CW +: CW]), 64'(m_cnt[t]));
        end
        chk("R9 retire_block", 64'(retire_block), 64'(allsq));
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare_all();
    endtask

    task automatic clear_pulses();
        trap_raise = '0; ctx_sq = '0; ex_vld = '0; ex_incl = '0; ex_mis = '0; ins_vld = '0;
    endtask

    initial begin
        clear_pulses();
        rob_done = '0; rob_empty = '1;
        ex_seq = '0; rob_head_seq = '0; last_cmt_seq = '0; ins_seq = '0;
        ex_pc = '0; resume_pc = '0;
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
        chk("R1 reset state", 64'(thr_state), 64'd0);
        chk("R1 reset bc_sq", 64'(bc_sq), 64'd0);
        chk("R1 reset block", 64'(retire_block), 64'd0);
        chk("R1 reset cnt", 64'(mis_cnt), 64'd0);

        // R2: insertion moves Idle to Running
        ins_vld = 2'b11; ins_seq = {8'd20, 8'd10};
        step(); clear_pulses();
        chk("R2 t0 running", 64'(thr_state[2:0]), 64'd1);

        // R3: younger than youngest valid is dropped
        ex_vld = 2'b01; ex_seq[7:0] = 8'd12;
        step(); clear_pulses();
        chk("R3 younger dropped", 64'(bc_sq[0]), 64'd0);

        // R4, R10: include-self mispredict squash
        ex_vld = 2'b01; ex_seq[7:0] = 8'd8; ex_incl = 2'b01; ex_mis = 2'b01; ex_pc[15:0] = 16'hBEEF;
        step(); clear_pulses();
        chk("R4 boundary", 64'(bc_done_seq[7:0]), 64'd7);
        chk("R4 pc", 64'(bc_pc[15:0]), 64'hBEEF);
        chk("R10 cnt one", 64'(mis_cnt[3:0]), 64'd1);
        step();
        chk("R5 pulse ends", 64'(bc_sq[0]), 64'd0);
        chk("R5 robsq held", 64'(bc_robsq[0]), 64'd1);
        rob_done = 2'b01;
        step(); rob_done = '0;
        chk("R2 back to running", 64'(thr_state[2:0]), 64'd1);

        // R6, R3, R11, R7, R8: trap on thread 1
        trap_raise = 2'b10;
        step(); clear_pulses();
        chk("R6 trap pending", 64'(thr_state[5:3]), 64'd3);
        chk("R6 inflight", 64'(trap_inflight[1]), 64'd1);
        ex_vld = 2'b10; ex_seq[15:8] = 8'd5;
        step(); clear_pulses();
        chk("R3 trap pending drop", 64'(bc_sq[1]), 64'd0);
        ctx_sq = 2'b10;
        step(); clear_pulses();
        chk("R11 ctx ignored", 64'(bc_sq[1]), 64'd0);
        ctx_sq = 2'b10; rob_empty = 2'b01; rob_head_seq[15:8] = 8'd30; resume_pc[31:16] = 16'h1234;
        step(); clear_pulses();
        chk("R7 head minus one", 64'(bc_done_seq[15:8]), 64'd29);
        chk("R7 resume pc", 64'(bc_pc[31:16]), 64'h1234);
        chk("R8 conflict", 64'(sq_conflict[1]), 64'd1);
        chk("R6 flag cleared", 64'(trap_inflight[1]), 64'd0);
        rob_done = 2'b11; rob_empty = 2'b11;
        step(); rob_done = '0;

        // R9: both squashing blocks insertion
        ex_vld = 2'b11; ex_seq = {8'd9, 8'd4};
        step(); clear_pulses();
        chk("R9 block raised", 64'(retire_block), 64'd1);
        ins_vld = 2'b11; ins_seq = {8'd99, 8'd99};
        step(); clear_pulses();
        chk("R9 block held", 64'(retire_block), 64'd1);
        rob_done = 2'b11;
        step(); rob_done = '0;
        ex_vld = 2'b01; ex_seq[7:0] = 8'd50;
        step(); clear_pulses();
        chk("R9 insertion ignored", 64'(bc_sq[0]), 64'd0);

        // R7: full squash with empty buffer
        ctx_sq = 2'b01; rob_empty = 2'b01; last_cmt_seq[7:0] = 8'd33;
        step(); clear_pulses();
        chk("R7 empty boundary", 64'(bc_done_seq[7:0]), 64'd33);

        // random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            for (int t = 0; t < NT; t++) begin
                ins_vld[t]    = ($urandom_range(0, 99) < 30);
                ex_vld[t]     = ($urandom_range(0, 99) < 15);
                ctx_sq[t]     = ($urandom_range(0, 99) < 3);
                trap_raise[t] = ($urandom_range(0, 99) < 4);
                rob_done[t]   = ($urandom_range(0, 99) < 40);
                rob_empty[t]  = ($urandom_range(0, 99) < 30);
                ex_incl[t]    = 1'($urandom_range(0, 1));
                ex_mis[t]     = 1'($urandom_range(0, 1));
                ex_seq[t*SW +: SW]       = SW'($urandom_range(0, SM));
                ins_seq[t*SW +: SW]      = SW'($urandom_range(0, SM));
                rob_head_seq[t*SW +: SW] = SW'($urandom_range(0, SM));
                last_cmt_seq[t*SW +: SW] = SW'($urandom_range(0, SM));
                ex_pc[t*PW +: PW]        = PW'($urandom_range(0, 65535));
                resume_pc[t*PW +: PW]    = PW'($urandom_range(0, 65535));
            end
            step();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule